// File: doc/BRIEF.md
# Effective Address Generation Sequencer

This unit sits between an 8-bit processor's decoder and its memory path and works out where an instruction's operand lives. For each request it takes a mode code, the one or two operand bytes that follow the opcode, the X and Y index registers, the location counter and two qualifiers from the decoder: whether the instruction is a conditional branch and whether it is the unconditional jump. It then produces a 16-bit effective address, or reports that the operand is a register or an immediate byte, or that the mode/instruction pairing is not permitted.

Modes that need only arithmetic finish one cycle after acceptance. Modes that go through a pointer fetch two bytes, low byte first, through a byte-wide read port. That port holds `mem_req` and `mem_addr` steady until `mem_rvalid` returns. The low byte sits at the lower address. Pointers stored on the base page wrap within it. Absolute pointers step across the full 16 bits. A page-cross flag tells the caller when an indexed or relative add moved the high address byte, so the caller can charge an extra cycle.

Requests use a valid/ready handshake. Only one request is in flight at a time. `req_ready` is high only while the unit is idle. A result stays on `res_valid` with every result field frozen until the consumer takes it with `res_ready`, so the consumer may apply back-pressure for any number of cycles.

Top module: `ea_seq`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no request is in flight and no result is waiting. While `res_valid` is high and `res_ready` is low, `res_addr`, `res_kind` and `res_cross` keep their values.
- R2: Result kinds are 0 = address, 1 = register, 2 = immediate, 3 = rejected. Mode 0 (register) gives kind 1 with address 0. Mode 1 (immediate) gives kind 2, with `res_addr` = {8'h00, `op_lo`}.
- R3: Mode 3 (zero page) gives {8'h00, `op_lo`}. Mode 5 (zero page indexed) gives {8'h00, (`op_lo` + index) mod 256}, where the index is X when `idx_sel` = 0 and Y when `idx_sel` = 1. Both report no page cross.
- R4: Mode 4 (absolute) gives {`op_hi`, `op_lo`}. Mode 6 (absolute indexed) gives ({`op_hi`, `op_lo`} + index) mod 65536, using the same index select as R3. `res_cross` is 1 exactly when the high byte differs from `op_hi`.
- R5: Mode 2 (relative) with `is_branch` = 1 gives `pc` plus `op_lo` sign-extended to 16 bits. `res_cross` is 1 exactly when the high byte differs from that of `pc`. With `is_branch` = 0 the result is kind 3, address 0.
- R6: Mode 7 (indirect) with `is_jump` = 1 reads the byte at {`op_hi`, `op_lo`}, then the byte at that address + 1 mod 65536. The result is {second byte, first byte}. With `is_jump` = 0 it gives kind 3 and makes no read.
- R7: Mode 8 (indexed indirect) reads at z = (`op_lo` + X) mod 256, then at (z + 1) mod 256, both with the high address byte 0. The result is {second byte, first byte} with no page cross.
- R8: Mode 9 (indirect indexed) reads at `op_lo`, then at (`op_lo` + 1) mod 256, on the base page. The result is ({second, first} + Y) mod 65536. `res_cross` is 1 when the sum's high byte differs from the second byte.
- R9: During a read, `mem_addr` stays stable and `mem_req` stays high until a cycle with `mem_rvalid` high. `mem_rvalid` has no effect while `mem_req` is low.
- R10: A mode without a pointer raises `res_valid` in the cycle after acceptance. A pointer mode raises it in the cycle after the edge that takes the second read byte.
- R11: Mode codes 10 to 15 give kind 3, address 0, no page cross and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_mode | input | 4 | Addressing mode code |
| req_idx_sel | input | 1 | Index for modes 5 and 6: 0 = X, 1 = Y |
| req_is_branch | input | 1 | Instruction is a conditional branch |
| req_is_jump | input | 1 | Instruction is the unconditional jump |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| x_reg | input | 8 | X index register |
| y_reg | input | 8 | Y index register |
| pc | input | 16 | Location counter |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes result |
| res_addr | output | 16 | Effective address or immediate byte |
| res_kind | output | 2 | Result kind |
| res_cross | output | 1 | Index or offset add changed the high byte |

## Verification
Two events can fall in the same cycle: a read byte returning in the very cycle its request first appears, and the pointer's final add with its page-cross decision. Zero-wait responses bring these together. The bench provokes this by returning `mem_rvalid` with no wait states on a random share of reads, mixed with delayed responses and stray valid pulses while no request is open. The address, the page-cross flag and the exact result cycle are then judged against the bench's own model. A second pairing is a waiting result held under back-pressure while `req_ready` must stay low. The bench provokes it by holding `res_ready` low for random stretches and checks that the result fields stay frozen.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam logic [3:0] M_REG  = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_REL  = 4'd2;
  localparam logic [3:0] M_ZP   = 4'd3;
  localparam logic [3:0] M_ABS  = 4'd4;
  localparam logic [3:0] M_ZPI  = 4'd5;
  localparam logic [3:0] M_ABSI = 4'd6;
  localparam logic [3:0] M_IND  = 4'd7;
  localparam logic [3:0] M_IZX  = 4'd8;
  localparam logic [3:0] M_IZY  = 4'd9;

  typedef enum logic [1:0] {
    K_ADDR = 2'd0,
    K_REG  = 2'd1,
    K_IMM  = 2'd2,
    K_BAD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RDLO = 2'd1,
    S_RDHI = 2'd2,
    S_OUT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import ea_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [3:0]     mode,
  input  logic           idx_sel,
  input  logic           is_branch,
  input  logic           is_jump,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   xr,
  input  logic [W-1:0]   yr,
  input  logic [2*W-1:0] loc,
  output logic [2*W-1:0] d_addr,
  output kind_e          d_kind,
  output logic           d_cross,
  output logic           need_ptr,
  output logic           ptr_zp,
  output logic           post_y,
  output logic [2*W-1:0] ptr_base
);
  localparam int A = 2 * W;

  logic [W-1:0] idx;
  logic [A-1:0] abs_a, abs_sum, rel_sum;
  logic [W-1:0] zpi_lo, izx_lo;

  assign idx     = idx_sel ? yr : xr;
  assign abs_a   = {hi, lo};
  assign abs_sum = abs_a + {{W{1'b0}}, idx};
  assign rel_sum = loc + {{W{lo[W-1]}}, lo};
  assign zpi_lo  = lo + idx;
  assign izx_lo  = lo + xr;

  always_comb begin
    d_addr   = '0;
    d_kind   = K_BAD;
    d_cross  = 1'b0;
    need_ptr = 1'b0;
    ptr_zp   = 1'b0;
    post_y   = 1'b0;
    ptr_base = '0;
    unique case (mode)
      M_REG: d_kind = K_REG;
      M_IMM: begin
        d_kind = K_IMM;
        d_addr = {{W{1'b0}}, lo};
      end
      M_REL: if (is_branch) begin
        d_kind  = K_ADDR;
        d_addr  = rel_sum;
        d_cross = rel_sum[A-1:W] != loc[A-1:W];
      end
      M_ZP: begin
        d_kind = K_ADDR;
        d_addr = {{W{1'b0}}, lo};
      end
      M_ABS: begin
        d_kind = K_ADDR;
        d_addr = abs_a;
      end
      M_ZPI: begin
        d_kind = K_ADDR;
        d_addr = {{W{1'b0}}, zpi_lo};
      end
      M_ABSI: begin
        d_kind  = K_ADDR;
        d_addr  = abs_sum;
        d_cross = abs_sum[A-1:W] != hi;
      end
      M_IND: if (is_jump) begin
        d_kind   = K_ADDR;
        need_ptr = 1'b1;
        ptr_base = abs_a;
      end
      M_IZX: begin
        d_kind   = K_ADDR;
        need_ptr = 1'b1;
        ptr_zp   = 1'b1;
        ptr_base = {{W{1'b0}}, izx_lo};
      end
      M_IZY: begin
        d_kind   = K_ADDR;
        need_ptr = 1'b1;
        ptr_zp   = 1'b1;
        post_y   = 1'b1;
        ptr_base = {{W{1'b0}}, lo};
      end
      default: d_kind = K_BAD;
    endcase
  end

  // R11 / R5 / R6: a rejected result never carries an address or a fetch
  always_comb begin
    if (d_kind == K_BAD)
      p_bad_is_empty_r11: assert (d_addr == '0 && !need_ptr && !d_cross);
  end
endmodule

// File: rtl/ea_ptr_tail.sv
module ea_ptr_tail #(
  parameter int W = ea_pkg::DW
) (
  input  logic [2*W-1:0] base,
  input  logic           zp,
  input  logic           post_y,
  input  logic [W-1:0]   yr,
  input  logic [W-1:0]   lo_byte,
  input  logic [W-1:0]   hi_byte,
  output logic [2*W-1:0] next_addr,
  output logic [2*W-1:0] final_addr,
  output logic           final_cross
);
  localparam int A = 2 * W;

  logic [W-1:0] zp_next;
  logic [A-1:0] ptr;

  assign zp_next    = base[W-1:0] + 1'b1;
  assign next_addr  = zp ? {{W{1'b0}}, zp_next} : base + 1'b1;
  assign ptr        = {hi_byte, lo_byte};

  generate
    if (W > 0) begin : g_post
      logic [A-1:0] sum;
      assign sum         = ptr + {{W{1'b0}}, yr};
      assign final_addr  = post_y ? sum : ptr;
      assign final_cross = post_y && (sum[A-1:W] != hi_byte);
    end
  endgenerate
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic          req_idx_sel,
  input  logic          req_is_branch,
  input  logic          req_is_jump,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] x_reg,
  input  logic [DW-1:0] y_reg,
  input  logic [AW-1:0] pc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_addr,
  output logic [1:0]    res_kind,
  output logic          res_cross
);
  seq_state_e st;
  logic [AW-1:0] base_q, addr_q;
  logic [DW-1:0] lo_q, y_q;
  logic [3:0]    mode_q;
  logic          zp_q, post_q, cross_q;
  kind_e         kind_q;

  logic [AW-1:0] d_addr, ptr_base, next_addr, final_addr;
  kind_e         d_kind;
  logic          d_cross, need_ptr, ptr_zp, post_y, final_cross;
  logic          take;

  ea_direct #(.W(DW)) u_direct (
    .mode(req_mode), .idx_sel(req_idx_sel), .is_branch(req_is_branch),
    .is_jump(req_is_jump), .lo(op_lo), .hi(op_hi), .xr(x_reg), .yr(y_reg),
    .loc(pc), .d_addr(d_addr), .d_kind(d_kind), .d_cross(d_cross),
    .need_ptr(need_ptr), .ptr_zp(ptr_zp), .post_y(post_y), .ptr_base(ptr_base)
  );

  ea_ptr_tail #(.W(DW)) u_tail (
    .base(base_q), .zp(zp_q), .post_y(post_q), .yr(y_q),
    .lo_byte(lo_q), .hi_byte(mem_rdata), .next_addr(next_addr),
    .final_addr(final_addr), .final_cross(final_cross)
  );

  assign req_ready = (st == S_IDLE);
  assign take      = req_valid && req_ready;
  assign mem_req   = (st == S_RDLO) || (st == S_RDHI);
  assign mem_addr  = (st == S_RDLO) ? base_q : (st == S_RDHI) ? next_addr : '0;
  assign res_valid = (st == S_OUT);
  assign res_addr  = addr_q;
  assign res_kind  = kind_q;
  assign res_cross = cross_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      y_q     <= '0;
      mode_q  <= '0;
      zp_q    <= 1'b0;
      post_q  <= 1'b0;
      cross_q <= 1'b0;
      kind_q  <= K_REG;
    end else begin
      unique case (st)
        S_IDLE: if (take) begin
          mode_q  <= req_mode;
          base_q  <= ptr_base;
          zp_q    <= ptr_zp;
          post_q  <= post_y;
          y_q     <= y_reg;
          kind_q  <= d_kind;
          addr_q  <= d_addr;
          cross_q <= d_cross;
          st      <= need_ptr ? S_RDLO : S_OUT;
        end
        S_RDLO: if (mem_rvalid) begin
          lo_q <= mem_rdata;
          st   <= S_RDHI;
        end
        S_RDHI: if (mem_rvalid) begin
          addr_q  <= final_addr;
          cross_q <= final_cross;
          st      <= S_OUT;
        end
        S_OUT: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: a waiting result is frozen until taken
  p_res_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr)
                               && $stable(res_kind) && $stable(res_cross));

  // R1: no new request while busy
  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req) |-> !req_ready);

  // R3: zero page results stay on the base page
  p_zp_page0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (mode_q == M_ZP || mode_q == M_ZPI) |-> res_addr[AW-1:DW] == '0);

  // R7 / R8: base-page pointer fetches never leave the base page
  p_bp_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && zp_q |-> mem_addr[AW-1:DW] == '0);

  // R9: open read keeps its address until data returns
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R6 / R11: only pointer modes read memory
  p_reads_only_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mode_q == M_IND || mode_q == M_IZX || mode_q == M_IZY));

  // R8: page cross from a pointer fetch only in the post-indexed mode
  p_cross_izy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cross |-> (mode_q == M_IZY || mode_q == M_ABSI || mode_q == M_REL));
endmodule

// File: tb/ea_seq_tb.sv
module ea_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_idx_sel = 1'b0, req_is_branch = 1'b0, req_is_jump = 1'b0;
  logic [3:0]  req_mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, x_reg = '0, y_reg = '0, mem_rdata = '0;
  logic [15:0] pc = '0;
  logic        mem_rvalid = 1'b0, res_ready = 1'b0;
  logic        req_ready, mem_req, res_valid, res_cross;
  logic [15:0] mem_addr, res_addr;
  logic [1:0]  res_kind;

  int checks = 0, fails = 0, ncyc = 0;
  int rd_n = 0, last_rv = 0, wait_cnt = 0;
  logic [15:0] rd_a [0:3];
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  ea_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_idx_sel(req_idx_sel), .req_is_branch(req_is_branch),
    .req_is_jump(req_is_jump), .op_lo(op_lo), .op_hi(op_hi), .x_reg(x_reg),
    .y_reg(y_reg), .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_kind(res_kind), .res_cross(res_cross)
  );

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // memory model: random wait states, stray valid pulses while no read is open
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mf(mem_addr);
          if (rd_n < 4) rd_a[rd_n] = mem_addr;
          rd_n++;
          last_rv  = ncyc;
          wait_cnt = ($urandom % 3 == 0) ? 0 : int'($urandom % 3);
        end else wait_cnt--;
      end else if ($urandom % 6 == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = 8'hEE;
      end
    end
  end

  task automatic model(input logic [3:0] m, input logic isel, br, jmp,
                       input logic [7:0] lo, hi, x, y, input logic [15:0] loc,
                       output logic [15:0] ea, output logic [1:0] k, output logic cr,
                       output int nrd, output logic [15:0] a0, output logic [15:0] a1);
    logic [7:0] ix;
    logic [15:0] p;
    ix = isel ? y : x;
    ea = '0; k = 2'd3; cr = 1'b0; nrd = 0; a0 = '0; a1 = '0;
    case (m)
      4'd0: k = 2'd1;
      4'd1: begin k = 2'd2; ea = {8'h00, lo}; end
      4'd2: if (br) begin k = 0; ea = loc + {{8{lo[7]}}, lo}; cr = ea[15:8] != loc[15:8]; end
      4'd3: begin k = 0; ea = {8'h00, lo}; end
      4'd4: begin k = 0; ea = {hi, lo}; end
      4'd5: begin k = 0; ea = {8'h00, 8'(lo + ix)}; end
      4'd6: begin k = 0; ea = {hi, lo} + {8'h00, ix}; cr = ea[15:8] != hi; end
      4'd7: if (jmp) begin k = 0; nrd = 2; a0 = {hi, lo}; a1 = a0 + 16'd1; ea = {mf(a1), mf(a0)}; end
      4'd8: begin k = 0; nrd = 2; a0 = {8'h00, 8'(lo + x)}; a1 = {8'h00, 8'(a0[7:0] + 8'd1)};
                  ea = {mf(a1), mf(a0)}; end
      4'd9: begin k = 0; nrd = 2; a0 = {8'h00, lo}; a1 = {8'h00, 8'(lo + 8'd1)};
                  p = {mf(a1), mf(a0)}; ea = p + {8'h00, y}; cr = ea[15:8] != p[15:8]; end
      default: ;
    endcase
  endtask

  task automatic run(input logic [3:0] m, input logic isel, br, jmp,
                     input logic [7:0] lo, hi, x, y, input logic [15:0] loc);
    logic [15:0] ea, a0, a1, held;
    logic [1:0] k;
    logic cr;
    int nrd, acc, g, stall;
    string tag;
    model(m, isel, br, jmp, lo, hi, x, y, loc, ea, k, cr, nrd, a0, a1);
    case (m)
      4'd0, 4'd1: tag = "R2";
      4'd2: tag = "R5";
      4'd3, 4'd5: tag = "R3";
      4'd4, 4'd6: tag = "R4";
      4'd7: tag = "R6";
      4'd8: tag = "R7";
      4'd9: tag = "R8";
      default: tag = "R11";
    endcase
    @(negedge clk);
    rd_n = 0;
    req_mode = m; req_idx_sel = isel; req_is_branch = br; req_is_jump = jmp;
    op_lo = lo; op_hi = hi; x_reg = x; y_reg = y; pc = loc;
    req_valid = 1'b1;
    chk(req_ready === 1'b1, "R1 ready when idle", {31'd0, req_ready}, 1);
    acc = ncyc;
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!res_valid && g < 100) begin @(negedge clk); g++; end
    chk(res_valid === 1'b1, {tag, " result arrives"}, {31'd0, res_valid}, 1);
    chk(res_kind === k, {tag, " kind"}, {30'd0, res_kind}, {30'd0, k});
    chk(res_addr === ea, {tag, " address"}, {16'd0, res_addr}, {16'd0, ea});
    chk(res_cross === cr, {tag, " page cross"}, {31'd0, res_cross}, {31'd0, cr});
    chk(rd_n == nrd, {tag, " R9 read count"}, rd_n, nrd);
    if (nrd == 2 && rd_n == 2) begin
      chk(rd_a[0] === a0, {tag, " first read address"}, {16'd0, rd_a[0]}, {16'd0, a0});
      chk(rd_a[1] === a1, {tag, " second read address"}, {16'd0, rd_a[1]}, {16'd0, a1});
      chk(ncyc == last_rv + 1, "R10 pointer latency", ncyc, last_rv + 1);
    end else if (nrd == 0) begin
      chk(ncyc == acc + 1, "R10 direct latency", ncyc, acc + 1);
    end
    held = res_addr;
    stall = $urandom % 3;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(res_valid === 1'b1 && res_addr === held && req_ready === 1'b0,
          "R1 hold under back-pressure", {15'd0, req_ready, res_addr}, {16'd0, held});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", {31'd0, req_ready}, 1);
    chk(res_valid === 1'b0, "R1 reset no result", {31'd0, res_valid}, 0);
    chk(mem_req === 1'b0, "R9 reset no read", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_req === 1'b0 && req_ready === 1'b1, "R9 stray valid ignored while idle",
        {31'd0, mem_req}, 0);

    // directed corners
    run(4'd0, 0, 0, 0, 8'h12, 8'h34, 8'h01, 8'h02, 16'h1000);   // R2 register
    run(4'd1, 0, 0, 0, 8'hA5, 8'h34, 8'h01, 8'h02, 16'h1000);   // R2 immediate
    run(4'd5, 0, 0, 0, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h0);      // R3 zp index wrap (X)
    run(4'd5, 1, 0, 0, 8'hFF, 8'h77, 8'h00, 8'h01, 16'h0);      // R3 wrap via Y
    run(4'd6, 0, 0, 0, 8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0);      // R4 wrap across 16 bits
    run(4'd6, 1, 0, 0, 8'h80, 8'h12, 8'h00, 8'h90, 16'h0);      // R4 page cross
    run(4'd2, 0, 1, 0, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2010);   // R5 backwards crossing
    run(4'd2, 0, 1, 0, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h20F0);   // R5 forwards crossing
    run(4'd2, 0, 0, 0, 8'h05, 8'h00, 8'h00, 8'h00, 16'h2000);   // R5 rejected
    run(4'd7, 0, 0, 1, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0);      // R6 16-bit step
    run(4'd7, 0, 0, 0, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0);      // R6 rejected, no read
    run(4'd8, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0);      // R7 pointer wrap
    run(4'd8, 0, 0, 0, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0);      // R7 index then wrap
    run(4'd9, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0);      // R8 wrap and add
    run(4'd12, 0, 1, 1, 8'h11, 8'h22, 8'h33, 8'h44, 16'h5555);  // R11 undefined
    run(4'd15, 0, 0, 0, 8'h11, 8'h22, 8'h33, 8'h44, 16'h5555);  // R11 undefined

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [3:0] m;
      m = 4'($urandom % 12);
      if ($urandom % 8 == 0) m = 4'($urandom);
      run(m, 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0,
          8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule